// File: doc/BRIEF.md
# Ethernet PHY Status LED Controller

This block lights up to four status LEDs next to an Ethernet PHY. Each LED has four independent selectors, all held in a small register bank. Three of them choose a condition: one makes the LED light steadily, one makes it blink at a fast rate and one makes it blink at a slow rate. The fourth is a mask of activity events that briefly blank the LED. A global register holds the two blink rates, which apply to all LEDs. A second global register holds scan and complex-blink selectors. These are stored and read back, but they drive nothing.

The PHY core supplies its live status: link up, link speed, power-down, energy-efficient idle, auto-negotiation, analog self-test and cable diagnostics. It also supplies single-cycle transmit, receive and collision activity strobes. Software, or a management-frame decoder placed in front of this block, sets up the LEDs through a synchronous register port. A write takes effect at the clock edge. Read data arrives one cycle after the address is presented.

Top module: `phy_led_ctrl`

## Requirements
- R1: After a synchronous reset the ten registers read, in address order from 0x1E0, as 0x00C5, 0x0067, 0x0070, 0x0003, 0x0020, 0x0000, 0x0040, 0x0000, 0x0040, 0x0020. `reg_rdata` is registered. It shows the register at the address of the previous cycle, taken before any write made in that same cycle.
- R2: Bits 15:8 of read data are always zero. An address outside 0x1E0..0x1E9 reads as zero, and a write to such an address changes no register.
- R3: Address 0x1E0 is the global rate register: fast rate in bits 7:6, slow rate in bits 5:4. Address 0x1E1 is the global scan register. LED n uses address 0x1E2+2n (steady condition in bits 7:4, fast-blink condition in bits 3:0) and address 0x1E3+2n (slow-blink condition in bits 7:4, activity mask in bits 3:0). A write stores write-data bits 7:0.
- R4: Condition codes 1..7 are true when the link is up and the current speed is selected. Code bit 0 selects 10 Mbit/s (`link_speed`=0), bit 1 selects 100 Mbit/s (`link_speed`=1) and bit 2 selects 1000 Mbit/s (`link_speed`=2). `link_speed`=3 matches no code.
- R5: Code 8 follows power-down, 9 energy-efficient idle, 0xA auto-negotiation, 0xB analog self-test and 0xC cable diagnostics. Codes 0 and 0xD..0xF are never true.
- R6: A shared divider advances a 4-bit phase counter every CLK_HZ/32 clock cycles. The phase counter is zero after reset. For rate code c (0 = 2 Hz, 1 = 4 Hz, 2 = 8 Hz, 3 = 16 Hz), the blink level is bit (3-c) of the phase counter.
- R7: Each LED picks its level in this priority order: the fast-blink level if the fast condition is true; otherwise the slow-blink level if the slow condition is true; otherwise off while an activity stretch is running; otherwise on if the steady condition is true; otherwise off.
- R8: Mask bit 0 selects transmit, bit 1 receive and bit 2 collision; bit 3 is ignored. A selected event reloads a stretch of PULSE_CYC cycles. A single event blanks the LED from the second edge after it through the edge PULSE_CYC cycles later.
- R9: Writing the global scan register, or bits 3:0 of the global rate register, does not change any LED output.
- R10: `led` is registered and is low after reset. It reflects the inputs and register contents present before the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 10 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data (upper register half is reserved) |
| reg_rdata | output | 16 | Registered read data |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | 0 = 10, 1 = 100, 2 = 1000 Mbit/s |
| pdown | input | 1 | PHY powered down |
| eee_idle | input | 1 | Energy-efficient idle |
| aneg_busy | input | 1 | Auto-negotiation running |
| selftest_busy | input | 1 | Analog self-test running |
| cablediag_busy | input | 1 | Cable diagnostics running |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| col_act | input | 1 | Collision strobe |
| led | output | 4 | LED drive, one bit per LED |

## Verification
Two kinds of overlap can happen in one cycle. The first is an activity stretch on an LED whose fast-blink or steady condition is also true. The bench sets a steady link LED and strobes transmit, then checks that the LED goes dark for exactly the stretch window. It then turns on power-down as a fast-blink condition on the same LED and checks that blinking wins over both the stretch and the steady setting. The second overlap is a register write and a read of the same address in the same cycle. The bench provokes it during register programming and compares every cycle against a behavioural model that returns the old contents.

// File: rtl/phy_led_pkg.sv
// Package: shared types and the condition decoder for the LED controller.
// Assumes link_speed 0/1/2 = 10/100/1000 Mbit/s; 3 matches nothing.
package phy_led_pkg;

    typedef struct packed {
        logic       link_up;
        logic [1:0] speed;
        logic       pdown;
        logic       eee;
        logic       aneg;
        logic       selftest;
        logic       cablediag;
    } phy_stat_t;

    // Reset contents of the register bank, by register index
    function automatic logic [7:0] reset_value(input int idx);
        case (idx)
            0:       return 8'hC5;
            1:       return 8'h67;
            2:       return 8'h70;
            3:       return 8'h03;
            4:       return 8'h20;
            5:       return 8'h00;
            6:       return 8'h40;
            7:       return 8'h00;
            8:       return 8'h40;
            9:       return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

    // True when the 4-bit condition code is satisfied by the PHY status
    function automatic logic cond_hit(input logic [3:0] code, input phy_stat_t st);
        logic hit;
        hit = 1'b0;
        if (code[3] == 1'b0) begin
            case (st.speed)
                2'd0:    hit = st.link_up & code[0];
                2'd1:    hit = st.link_up & code[1];
                2'd2:    hit = st.link_up & code[2];
                default: hit = 1'b0;
            endcase
        end else begin
            case (code[2:0])
                3'd0:    hit = st.pdown;
                3'd1:    hit = st.eee;
                3'd2:    hit = st.aneg;
                3'd3:    hit = st.selftest;
                3'd4:    hit = st.cablediag;
                default: hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

endpackage

// File: rtl/led_regbank.sv
// Module: register bank holding the global and per-LED configuration bytes.
// Assumes bits 15:8 are reserved (never stored, read as zero); read data is
// registered and shows contents before a same-cycle write.
module led_regbank #(
    parameter int              ADDR_W    = 10,
    parameter logic [9:0]      BASE_ADDR = 10'h1E0,
    parameter int              NUM_LEDS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr_en,
    input  logic [7:0]               wdata,
    output logic [15:0]              rdata,
    output logic [1:0]               fast_rate,
    output logic [1:0]               slow_rate,
    output logic [NUM_LEDS-1:0][3:0] steady_sel,
    output logic [NUM_LEDS-1:0][3:0] fast_sel,
    output logic [NUM_LEDS-1:0][3:0] slow_sel,
    output logic [NUM_LEDS-1:0][2:0] act_mask
);
    import phy_led_pkg::*;

    localparam int NREG  = 2 + 2 * NUM_LEDS;
    localparam int IDX_W = $clog2(NREG);

    logic [7:0]        regs [NREG];
    logic [ADDR_W-1:0] offset;
    logic              hit;
    logic [IDX_W-1:0]  idx;

    // Decode the address into a register index and an in-range flag
    always_comb begin
        offset = addr - ADDR_W'(BASE_ADDR);
        hit    = (addr >= ADDR_W'(BASE_ADDR)) && (offset < ADDR_W'(NREG));
        idx    = offset[IDX_W-1:0];
    end

    // Store write data, or load reset contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= reset_value(i);
        end else if (wr_en && hit) begin
            regs[idx] <= wdata;
        end
    end

    // Register the read data
    always_ff @(posedge clk) begin
        if (!rst_n)   rdata <= '0;
        else if (hit) rdata <= {8'h00, regs[idx]};
        else          rdata <= '0;
    end

    assign fast_rate = regs[0][7:6];
    assign slow_rate = regs[0][5:4];

    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_fields
        assign steady_sel[g] = regs[2 + 2 * g][7:4];
        assign fast_sel[g]   = regs[2 + 2 * g][3:0];
        assign slow_sel[g]   = regs[3 + 2 * g][7:4];
        assign act_mask[g]   = regs[3 + 2 * g][2:0];
    end

endmodule

// File: rtl/led_blink_gen.sv
// Module: shared divider producing the fast and slow blink levels at 50% duty.
// Assumes CLK_HZ >= 32; the phase counter steps every CLK_HZ/32 cycles.
module led_blink_gen #(
    parameter int CLK_HZ = 125_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] fast_rate,
    input  logic [1:0] slow_rate,
    output logic       fast_wave,
    output logic       slow_wave
);
    localparam int TICK_CYC = CLK_HZ / 32;
    localparam int CNT_W    = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

    logic [CNT_W-1:0] div_cnt;
    logic [3:0]       phase;

    // Divide the clock and advance the phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            phase   <= '0;
        end else if (div_cnt == CNT_W'(TICK_CYC - 1)) begin
            div_cnt <= '0;
            phase   <= phase + 4'd1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Select one phase bit per rate: higher code means a lower bit
    always_comb begin
        fast_wave = phase[2'd3 - fast_rate];
        slow_wave = phase[2'd3 - slow_rate];
    end

endmodule

// File: rtl/led_channel.sv
// Module: one LED; evaluates its conditions, stretches activity, resolves priority.
// Assumes activity strobes are synchronous to clk.
module led_channel #(
    parameter int PULSE_CYC = 6_250_000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  phy_led_pkg::phy_stat_t stat,
    input  logic [2:0]             act,
    input  logic [3:0]             steady_sel,
    input  logic [3:0]             fast_sel,
    input  logic [3:0]             slow_sel,
    input  logic [2:0]             act_mask,
    input  logic                   fast_wave,
    input  logic                   slow_wave,
    output logic                   led
);
    import phy_led_pkg::*;

    localparam int PW = $clog2(PULSE_CYC + 1);

    logic [PW-1:0] stretch;
    logic          led_nx;

    // Reload the stretch on a masked event, otherwise count it down
    always_ff @(posedge clk) begin
        if (!rst_n)                  stretch <= '0;
        else if (|(act & act_mask))  stretch <= PW'(PULSE_CYC);
        else if (stretch != '0)      stretch <= stretch - 1'b1;
    end

    // Priority: fast blink, slow blink, activity blank, steady, off
    always_comb begin
        if (cond_hit(fast_sel, stat))        led_nx = fast_wave;
        else if (cond_hit(slow_sel, stat))   led_nx = slow_wave;
        else if (stretch != '0)              led_nx = 1'b0;
        else                                 led_nx = cond_hit(steady_sel, stat);
    end

    // Register the LED drive
    always_ff @(posedge clk) begin
        if (!rst_n) led <= 1'b0;
        else        led <= led_nx;
    end

endmodule

// File: rtl/phy_led_ctrl.sv
// Module: top of the PHY status LED controller; a register bank, a shared
// blink divider and one channel per LED. Assumes all inputs are synchronous.
module phy_led_ctrl #(
    parameter int         CLK_HZ    = 125_000_000,
    parameter int         PULSE_CYC = 6_250_000,
    parameter int         NUM_LEDS  = 4,
    parameter int         ADDR_W    = 10,
    parameter logic [9:0] BASE_ADDR = 10'h1E0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [7:0]          reg_wdata,
    output logic [15:0]         reg_rdata,
    input  logic                link_up,
    input  logic [1:0]          link_speed,
    input  logic                pdown,
    input  logic                eee_idle,
    input  logic                aneg_busy,
    input  logic                selftest_busy,
    input  logic                cablediag_busy,
    input  logic                tx_act,
    input  logic                rx_act,
    input  logic                col_act,
    output logic [NUM_LEDS-1:0] led
);
    import phy_led_pkg::*;

    localparam int NUM_REGS = 2 + 2 * NUM_LEDS;

    logic [1:0]               fast_rate, slow_rate;
    logic [NUM_LEDS-1:0][3:0] steady_sel, fast_sel, slow_sel;
    logic [NUM_LEDS-1:0][2:0] act_mask;
    logic                     fast_wave, slow_wave;
    phy_stat_t                stat;
    logic [2:0]               act;

    // Gather the PHY status into one bundle
    always_comb begin
        stat = '{link_up: link_up, speed: link_speed, pdown: pdown,
                 eee: eee_idle, aneg: aneg_busy, selftest: selftest_busy,
                 cablediag: cablediag_busy};
        act  = {col_act, rx_act, tx_act};
    end

    led_regbank #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_LEDS(NUM_LEDS)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr),
        .wdata(reg_wdata), .rdata(reg_rdata), .fast_rate(fast_rate),
        .slow_rate(slow_rate), .steady_sel(steady_sel), .fast_sel(fast_sel),
        .slow_sel(slow_sel), .act_mask(act_mask)
    );

    led_blink_gen #(.CLK_HZ(CLK_HZ)) u_blink (
        .clk(clk), .rst_n(rst_n), .fast_rate(fast_rate), .slow_rate(slow_rate),
        .fast_wave(fast_wave), .slow_wave(slow_wave)
    );

    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_led
        led_channel #(.PULSE_CYC(PULSE_CYC)) u_chan (
            .clk(clk), .rst_n(rst_n), .stat(stat), .act(act),
            .steady_sel(steady_sel[g]), .fast_sel(fast_sel[g]),
            .slow_sel(slow_sel[g]), .act_mask(act_mask[g]),
            .fast_wave(fast_wave), .slow_wave(slow_wave), .led(led[g])
        );
    end

endmodule

// File: rtl/led_ctrl_checker.sv
// Module: protocol and behaviour properties for phy_led_ctrl, bound below.
module led_ctrl_checker #(
    parameter int         ADDR_W    = 10,
    parameter logic [9:0] BASE_ADDR = 10'h1E0,
    parameter int         NUM_REGS  = 10,
    parameter int         NUM_LEDS  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wr,
    input logic [7:0]          reg_wdata,
    input logic [15:0]         reg_rdata,
    input logic                link_up,
    input logic                pdown,
    input logic                eee_idle,
    input logic                aneg_busy,
    input logic                selftest_busy,
    input logic                cablediag_busy,
    input logic [NUM_LEDS-1:0] led
);
    logic in_range;
    assign in_range = (reg_addr >= ADDR_W'(BASE_ADDR)) &&
                      (reg_addr < ADDR_W'(BASE_ADDR) + ADDR_W'(NUM_REGS));

    // R10: reset leaves the LEDs dark and the read data zero
    a_r10_reset_dark: assert property (@(posedge clk)
        !rst_n |=> (led == '0 && reg_rdata == '0));

    // R2: reserved upper half never carries data
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[15:8] == 8'h00);

    // R2: out-of-range addresses read zero
    a_r2_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |=> reg_rdata == 16'h0000);

    // R3: a write is visible to a read of the same address on the next cycle
    a_r3_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && in_range) ##1 (!reg_wr && reg_addr == $past(reg_addr))
        |=> reg_rdata == {8'h00, $past(reg_wdata, 2)});

    // R5: with no status source active no LED can be lit
    a_r5_no_source_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && !pdown && !eee_idle && !aneg_busy && !selftest_busy
         && !cablediag_busy) |=> led == '0);

endmodule

bind phy_led_ctrl led_ctrl_checker #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS), .NUM_LEDS(NUM_LEDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
    .pdown(pdown), .eee_idle(eee_idle), .aneg_busy(aneg_busy),
    .selftest_busy(selftest_busy), .cablediag_busy(cablediag_busy), .led(led)
);

// File: tb/test_phy_led_ctrl.sv
// Bench: behavioural per-cycle model of phy_led_ctrl plus directed checks.
module test_phy_led_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 320;
    localparam int PULSE_CYC  = 6;
    localparam int TICK       = CLK_HZ / 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  reg_addr = 10'h000;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [15:0] reg_rdata;
    logic        link_up = 0, pdown = 0, eee_idle = 0, aneg_busy = 0;
    logic        selftest_busy = 0, cablediag_busy = 0;
    logic        tx_act = 0, rx_act = 0, col_act = 0;
    logic [1:0]  link_speed = 2'd0;
    logic [3:0]  led;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    phy_led_ctrl #(.CLK_HZ(CLK_HZ), .PULSE_CYC(PULSE_CYC)) i_phy_led_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
        .link_speed(link_speed), .pdown(pdown), .eee_idle(eee_idle),
        .aneg_busy(aneg_busy), .selftest_busy(selftest_busy),
        .cablediag_busy(cablediag_busy), .tx_act(tx_act), .rx_act(rx_act),
        .col_act(col_act), .led(led)
    );

    // ---------------- reference model ----------------
    int        mreg [10];
    int        mcnt, mphase;
    int        mstretch [4];
    int        exp_led, exp_rd;
    bit        started = 0;

    function automatic bit cond_ok(int code);
        if (code >= 1 && code <= 7)
            return link_up && ((link_speed == 0 && (code & 1) != 0) ||
                               (link_speed == 1 && (code & 2) != 0) ||
                               (link_speed == 2 && (code & 4) != 0));
        if (code == 8)  return pdown;
        if (code == 9)  return eee_idle;
        if (code == 10) return aneg_busy;
        if (code == 11) return selftest_busy;
        if (code == 12) return cablediag_busy;
        return 0;
    endfunction

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            mreg = '{8'hC5, 8'h67, 8'h70, 8'h03, 8'h20, 8'h00, 8'h40, 8'h00, 8'h40, 8'h20};
            mcnt = 0; mphase = 0; exp_led = 0; exp_rd = 0;
            for (int i = 0; i < 4; i++) mstretch[i] = 0;
        end else begin
            int fw, sw, ev, a;
            a      = int'(reg_addr) - 'h1E0;
            exp_rd = (a >= 0 && a < 10) ? mreg[a] : 0;
            fw = (mphase >> (3 - ((mreg[0] >> 6) & 3))) & 1;
            sw = (mphase >> (3 - ((mreg[0] >> 4) & 3))) & 1;
            exp_led = 0;
            for (int i = 0; i < 4; i++) begin
                int h, l, bitv;
                h = mreg[2 + 2 * i]; l = mreg[3 + 2 * i];
                if (cond_ok(h & 15))          bitv = fw;
                else if (cond_ok(l >> 4))     bitv = sw;
                else if (mstretch[i] > 0)     bitv = 0;
                else                          bitv = cond_ok(h >> 4) ? 1 : 0;
                exp_led |= bitv << i;
                ev = (l & 7) & {29'd0, col_act, rx_act, tx_act};
                if (ev != 0)                mstretch[i] = PULSE_CYC;
                else if (mstretch[i] > 0)   mstretch[i] = mstretch[i] - 1;
            end
            if (reg_wr && a >= 0 && a < 10) mreg[a] = int'(reg_wdata);
            if (mcnt == TICK - 1) begin mcnt = 0; mphase = (mphase + 1) % 16; end
            else mcnt = mcnt + 1;
        end
    end

    // Compare every cycle away from the active edge (R5 R6 R7 R8 R9 R10 R1)
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (int'(led) != exp_led || int'(reg_rdata) != exp_rd) begin
                errors++;
                $display("FAIL R7 model compare t=%0t led=%h exp %h rdata=%h exp %h",
                         $time, led, exp_led, reg_rdata, exp_rd);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_addr = 10'(addr); reg_wdata = 8'(data); reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_check(input int addr, input int expv, input string req);
        @(negedge clk);
        reg_addr = 10'(addr);
        @(negedge clk);
        check(int'(reg_rdata) == expv, req, int'(reg_rdata), expv);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int lo, hi;
        repeat (3) @(negedge clk);
        check(led == 4'h0, "R10 reset led", int'(led), 0);
        rst_n = 1;

        // R1 / R3: reset contents in address order
        rd_check('h1E0, 'h00C5, "R1 global rate");
        rd_check('h1E1, 'h0067, "R1 global scan");
        rd_check('h1E2, 'h0070, "R1 led0 hi");
        rd_check('h1E3, 'h0003, "R1 led0 lo");
        rd_check('h1E9, 'h0020, "R1 led3 lo");
        rd_check('h1EA, 'h0000, "R2 out of range");

        // R4: link at 100 Mbit/s
        link_up = 1; link_speed = 2'd1;
        repeat (3) @(negedge clk);
        check(led[1] == 1'b1, "R4 led1 at 100M", int'(led[1]), 1);
        check(led[2] == 1'b0, "R4 led2 idle at 100M", int'(led[2]), 0);
        link_speed = 2'd3;
        repeat (3) @(negedge clk);
        check(led[0] == 1'b0, "R4 speed 3 matches nothing", int'(led[0]), 0);
        link_speed = 2'd2;
        repeat (3) @(negedge clk);
        check(led[0] == 1'b1, "R4 led0 at 1000M", int'(led[0]), 1);

        // R8: transmit strobe blanks steady led0 for PULSE_CYC edges
        @(negedge clk); tx_act = 1;
        @(negedge clk); tx_act = 0;
        @(negedge clk);
        check(led[0] == 1'b0, "R8 stretch blanks", int'(led[0]), 0);
        repeat (PULSE_CYC - 1) @(negedge clk);
        check(led[0] == 1'b0, "R8 stretch last edge", int'(led[0]), 0);
        @(negedge clk);
        check(led[0] == 1'b1, "R8 stretch ends", int'(led[0]), 1);

        // R8: reserved mask bit and unselected collision have no effect
        wr('h1E3, 'h08);
        @(negedge clk); tx_act = 1; col_act = 1;
        @(negedge clk); tx_act = 0; col_act = 0;
        lo = 0;
        repeat (PULSE_CYC + 2) begin @(negedge clk); if (led[0] == 0) lo++; end
        check(lo == 0, "R8 bit3 mask ignored", lo, 0);

        // R7 / R6: fast blink on power-down overrides steady and stretch
        wr('h1E2, 'h78);
        wr('h1E3, 'h01);
        pdown = 1;
        @(negedge clk); tx_act = 1;
        @(negedge clk); tx_act = 0;
        lo = 0; hi = 0;
        repeat (4 * TICK) begin @(negedge clk); if (led[0]) hi++; else lo++; end
        check(lo > 0 && hi > 0, "R7 fast blink wins", hi, 2 * TICK);
        check(hi == 2 * TICK, "R6 16Hz duty", hi, 2 * TICK);

        // R6: slow rate 2 Hz on led1 via slow condition (pdown)
        wr('h1E5, 'h80);
        lo = 0; hi = 0;
        repeat (32 * TICK) begin @(negedge clk); if (led[1]) hi++; else lo++; end
        check(hi == 16 * TICK, "R6 2Hz duty", hi, 16 * TICK);
        pdown = 0;

        // R5: reserved codes never true, EEE code 9 true
        wr('h1E4, 'hD9);
        wr('h1E5, 'hF0);
        eee_idle = 1; aneg_busy = 1; selftest_busy = 1; cablediag_busy = 1;
        wr('h1E0, 'h05);
        repeat (3) @(negedge clk);
        wr('h1E4, 'hD0);
        repeat (3) @(negedge clk);
        check(led[1] == 1'b0, "R5 code D never true", int'(led[1]), 0);
        wr('h1E4, 'hA0);
        repeat (3) @(negedge clk);
        check(led[1] == 1'b1, "R5 code A auto-neg", int'(led[1]), 1);
        eee_idle = 0; aneg_busy = 0; selftest_busy = 0; cablediag_busy = 0;

        // R9: scan register writes have no LED effect, read back intact
        wr('h1E1, 'h11);
        repeat (20) @(negedge clk);
        rd_check('h1E1, 'h0011, "R9 scan stored");

        // R2: write outside the range changes nothing; write/read same cycle
        wr('h1EA, 'h55);
        rd_check('h1EA, 'h0000, "R2 outside write ignored");
        @(negedge clk);
        reg_addr = 10'h1E6; reg_wdata = 8'h99; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
        check(int'(reg_rdata) == 'h40, "R1 read before same-cycle write", int'(reg_rdata), 'h40);
        @(negedge clk);
        check(int'(reg_rdata) == 'h99, "R3 write visible", int'(reg_rdata), 'h99);

        // R10: reset mid-run
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        check(led == 4'h0, "R10 reset mid-run", int'(led), 0);
        rst_n = 1;
        repeat (4) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule